// File: doc/BRIEF.md
# Validated Overcurrent Warning Threshold Register

This block keeps the overcurrent warning threshold of a power controller that is managed over a PMBus-style command interface. The threshold is a 16-bit word in linear format: a two's-complement exponent sits in the upper bits and an unsigned mantissa sits below it. Only the low seven bits can be written. Every write is checked against the fault threshold that the block receives alongside it. A write that would put the warning level above the fault level is refused. A refused write leaves the stored word as it was, raises the communication-error and invalid-data status flags, and pulls the active-low alert line. An override input turns the check off, so any write is accepted.

The value is not kept in nonvolatile storage. On each restore event the block therefore computes a fresh value: seven eighths of the fault threshold's mantissa, found as the mantissa minus the mantissa shifted right by three, with the fault threshold's exponent. The status flags are controlled by a two-state machine. In `ST_CLEAN` the flags are low and the alert is released. A refused write moves the machine from `ST_CLEAN` to `ST_FLAGGED` (transition "reject"). It stays in `ST_FLAGGED` through any further traffic ("hold") until a clear-status pulse comes in a cycle with no refused write ("clear"). That pulse returns it to `ST_CLEAN`. A refused write in the same cycle as the clear keeps the machine in `ST_FLAGGED`.

Top module: `ocw_limit_reg`

## Requirements
- R1: After reset the stored word is 0x0000, both status flags are low and `alert_n` is 1.
- R2: A write is accepted when its candidate mantissa is less than or equal to `fault_limit[10:0]`, compared as unsigned numbers. The candidate word is the stored bits 15:7 followed by `wr_data[6:0]`, and its mantissa is bits 10:0. An accepted write updates the stored word to the candidate word on the next clock edge, and an equal value counts as accepted.
- R3: A write whose candidate mantissa is greater than `fault_limit[10:0]` while `override_en` is 0 leaves the stored word unchanged.
- R4: Such a refused write sets `cml_flag` and `ivd_flag` to 1 and `alert_n` to 0 after the next clock edge.
- R5: While `override_en` is 1, every write is stored without the limit check and raises no flag.
- R6: Bits 15:7 of `wr_data` have no effect on the stored word.
- R7: A restore pulse loads bits 10:0 with M − (M >> 3), where M is `fault_limit[10:0]`, and loads bits 15:11 with `fault_limit[15:11]`, on the next edge. It leaves the status flags as they were.
- R8: When a restore and a write arrive in the same cycle, the restore is applied and the write is ignored: it neither stores anything nor raises a flag.
- R9: The flags and the alert stay set through later writes and restores until a clear-status pulse arrives. After that pulse's edge, both flags are 0 and `alert_n` is 1.
- R10: A clear-status pulse in the same cycle as a refused write leaves the flags set and `alert_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 16 | Written word; only bits 6:0 are used |
| fault_limit | input | 16 | Companion fault threshold in linear format |
| override_en | input | 1 | Turns off the limit check when 1 |
| restore | input | 1 | Restore pulse that loads the computed default |
| clr_status | input | 1 | Clears the status flags |
| limit_q | output | 16 | Stored warning threshold |
| cml_flag | output | 1 | Communication-error summary flag |
| ivd_flag | output | 1 | Invalid-data flag |
| alert_n | output | 1 | Alert, low when asserted |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 11-bit mantissa, 7 writable bits and a shift of three for the restore arithmetic. With these values, a restore from a large fault threshold puts non-zero values into the read-only mantissa bits 10:7. The bench can then refuse a write that exceeds the fault mantissa by exactly one, and accept a write that equals it, at a point where both the read-only and the writable bits take part in the comparison. It also covers a full-scale fault mantissa and a mantissa too small to lose anything to the shift.

// File: rtl/ocw_pkg.sv
package ocw_pkg;

    typedef enum logic [0:0] {
        ST_CLEAN   = 1'b0,
        ST_FLAGGED = 1'b1
    } ocw_state_e;

endpackage

// File: rtl/ocw_check.sv
module ocw_check #(
    parameter int DATA_W = 16,
    parameter int MANT_W = 11,
    parameter int WR_W   = 7,
    parameter int SHIFT  = 3
) (
    input  logic [DATA_W-1:0] cur_q,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] fault_lim,
    output logic [DATA_W-1:0] cand,
    output logic              too_high,
    output logic [DATA_W-1:0] dflt
);

    localparam int EXP_W = DATA_W - MANT_W;

    logic [MANT_W-1:0] fmant;
    logic [MANT_W-1:0] cmant;
    logic unused_wr_hi;
    logic unused_cur_lo;

    // Writable bits come from the write; the read-only field keeps its stored value.
    generate
        if (WR_W < DATA_W) begin : g_merge
            assign cand          = {cur_q[DATA_W-1:WR_W], wr_data[WR_W-1:0]};
            assign unused_wr_hi  = ^wr_data[DATA_W-1:WR_W];
            assign unused_cur_lo = ^cur_q[WR_W-1:0];
        end else begin : g_full
            assign cand          = wr_data;
            assign unused_wr_hi  = 1'b0;
            assign unused_cur_lo = ^cur_q;
        end
    endgenerate

    assign fmant    = fault_lim[MANT_W-1:0];
    assign cmant    = cand[MANT_W-1:0];
    assign too_high = cmant > fmant;

    // Restore default: seven eighths of the fault mantissa, same exponent.
    assign dflt = {fault_lim[DATA_W-1:DATA_W-EXP_W], fmant - (fmant >> SHIFT)};

endmodule

// File: rtl/ocw_store.sv
module ocw_store #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore,
    input  logic              wr_accept,
    input  logic [DATA_W-1:0] cand,
    input  logic [DATA_W-1:0] dflt,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (restore) begin
            q <= dflt;
        end else if (wr_accept) begin
            q <= cand;
        end
    end

    // R7: the restore loads the computed default
    a_r7_restore_load: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> q == $past(dflt));

    // R3: no load without restore or accepted write
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && !wr_accept) |=> $stable(q));

endmodule

// File: rtl/ocw_status.sv
module ocw_status
    import ocw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_err,
    input  logic clr,
    output logic cml,
    output logic ivd,
    output logic alert_n
);

    ocw_state_e state_q;
    ocw_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: begin
                if (set_err) state_d = ST_FLAGGED;   // reject
            end
            ST_FLAGGED: begin
                if (clr && !set_err) state_d = ST_CLEAN; // clear
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        cml     = 1'b0;
        ivd     = 1'b0;
        alert_n = 1'b1;
        unique case (state_q)
            ST_CLEAN: ;
            ST_FLAGGED: begin
                cml     = 1'b1;
                ivd     = 1'b1;
                alert_n = 1'b0;
            end
            default: ;
        endcase
    end

    // R10: an error in the clear cycle keeps the flags
    a_r10_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> (!alert_n && cml));

    // R9: a clear with no error releases the alert
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_err) |=> (alert_n && !ivd));

    // R9: flags stay sticky without a clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_n && !clr) |=> !alert_n);

endmodule

// File: rtl/ocw_limit_reg.sv
module ocw_limit_reg #(
    parameter int DATA_W = 16,
    parameter int MANT_W = 11,
    parameter int WR_W   = 7,
    parameter int SHIFT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] fault_limit,
    input  logic              override_en,
    input  logic              restore,
    input  logic              clr_status,
    output logic [DATA_W-1:0] limit_q,
    output logic              cml_flag,
    output logic              ivd_flag,
    output logic              alert_n
);

    logic [DATA_W-1:0] cand;
    logic [DATA_W-1:0] dflt;
    logic              too_high;
    logic              wr_live;
    logic              wr_accept;
    logic              set_err;

    // Restore has priority: a write in the same cycle is dropped entirely.
    assign wr_live   = wr_en && !restore;
    assign wr_accept = wr_live && (!too_high || override_en);
    assign set_err   = wr_live && too_high && !override_en;

    ocw_check #(
        .DATA_W (DATA_W),
        .MANT_W (MANT_W),
        .WR_W   (WR_W),
        .SHIFT  (SHIFT)
    ) u_check (
        .cur_q     (limit_q),
        .wr_data   (wr_data),
        .fault_lim (fault_limit),
        .cand      (cand),
        .too_high  (too_high),
        .dflt      (dflt)
    );

    ocw_store #(
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .restore   (restore),
        .wr_accept (wr_accept),
        .cand      (cand),
        .dflt      (dflt),
        .q         (limit_q)
    );

    ocw_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_err (set_err),
        .clr     (clr_status),
        .cml     (cml_flag),
        .ivd     (ivd_flag),
        .alert_n (alert_n)
    );

    // R3: a refused write keeps the stored word
    a_r3_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restore && !override_en &&
         (wr_data[WR_W-1:0] > fault_limit[WR_W-1:0]) &&
         (limit_q[MANT_W-1:WR_W] == fault_limit[MANT_W-1:WR_W]))
        |=> $stable(limit_q));

    // R4: a refused write raises both flags and the alert
    a_r4_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restore && !override_en && too_high)
        |=> (cml_flag && ivd_flag && !alert_n));

    // R6: a write never changes the read-only field
    a_r6_upper_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restore) |=> limit_q[DATA_W-1:WR_W] == $past(limit_q[DATA_W-1:WR_W]));

    // R5: an overridden write stores the writable bits and raises no new flag
    a_r5_override: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restore && override_en && alert_n && !clr_status)
        |=> (limit_q[WR_W-1:0] == $past(wr_data[WR_W-1:0]) && alert_n));

    // R8: a write beside a restore raises no flag
    a_r8_restore_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && alert_n) |=> alert_n);

endmodule

// File: tb/ocw_limit_reg_test.sv
module ocw_limit_reg_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] fault_limit = '0;
    logic        override_en = 1'b0;
    logic        restore = 1'b0;
    logic        clr_status = 1'b0;
    logic [15:0] limit_q;
    logic        cml_flag;
    logic        ivd_flag;
    logic        alert_n;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ocw_limit_reg uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .fault_limit (fault_limit),
        .override_en (override_en),
        .restore     (restore),
        .clr_status  (clr_status),
        .limit_q     (limit_q),
        .cml_flag    (cml_flag),
        .ivd_flag    (ivd_flag),
        .alert_n     (alert_n)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic chk_flags(input string tag, input logic flagged);
        chk({tag, " cml"}, {15'd0, cml_flag}, {15'd0, flagged});
        chk({tag, " ivd"}, {15'd0, ivd_flag}, {15'd0, flagged});
        chk({tag, " alert_n"}, {15'd0, alert_n}, {15'd0, !flagged});
    endtask

    // Drive one cycle from the falling edge, then sample just after the rising edge.
    task automatic step(input logic we, input logic [15:0] d, input logic rs, input logic cl);
        @(negedge clk);
        wr_en = we; wr_data = d; restore = rs; clr_status = cl;
        @(posedge clk);
        #1;
        wr_en = 1'b0; restore = 1'b0; clr_status = 1'b0;
    endtask

    function automatic logic [15:0] dflt_of(input logic [15:0] f);
        logic [10:0] m;
        m = f[10:0];
        return {f[15:11], m - (m >> 3)};
    endfunction

    task automatic t_reset();
        chk("R1 reset word", limit_q, 16'h0000);
        chk_flags("R1 reset", 1'b0);
    endtask

    task automatic t_accept();
        fault_limit = 16'h0050;
        step(1'b1, 16'hFF50, 1'b0, 1'b0);
        chk("R2 R6 equal accepted, upper ignored", limit_q, 16'h0050);
        step(1'b1, 16'h004F, 1'b0, 1'b0);
        chk("R2 below accepted", limit_q, 16'h004F);
        chk_flags("R2 no flags", 1'b0);
    endtask

    task automatic t_reject();
        step(1'b1, 16'h0051, 1'b0, 1'b0);
        chk("R3 rejected keeps word", limit_q, 16'h004F);
        chk_flags("R4 reject flags", 1'b1);
        step(1'b1, 16'h0010, 1'b0, 1'b0);
        chk("R9 accept while flagged", limit_q, 16'h0010);
        chk_flags("R9 sticky after write", 1'b1);
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        chk_flags("R9 R7 sticky after restore", 1'b1);
        step(1'b1, 16'h007F, 1'b0, 1'b1);
        chk_flags("R10 clear with reject", 1'b1);
        step(1'b0, 16'h0000, 1'b0, 1'b1);
        chk_flags("R9 clear", 1'b0);
    endtask

    task automatic t_override();
        fault_limit = 16'h0020;
        override_en = 1'b1;
        step(1'b1, 16'h007F, 1'b0, 1'b0);
        override_en = 1'b0;
        chk("R5 override stores", limit_q, 16'h007F);
        chk_flags("R5 override no flags", 1'b0);
    endtask

    task automatic t_restore();
        fault_limit = 16'hDC00;
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        chk("R7 restore 0xDC00", limit_q, dflt_of(16'hDC00));
        chk("R7 restore literal", limit_q, 16'hDB80);
        step(1'b1, 16'h007F, 1'b0, 1'b0);
        chk("R2 with read-only mantissa bits", limit_q, 16'hDBFF);
        fault_limit = 16'hDB90;
        step(1'b1, 16'h0011, 1'b0, 1'b0);
        chk("R3 one above fault", limit_q, 16'hDBFF);
        chk_flags("R4 one above fault", 1'b1);
        step(1'b1, 16'h0010, 1'b0, 1'b1);
        chk("R2 equal to fault", limit_q, 16'hDB90);
        chk_flags("R9 clear after boundary", 1'b0);
        fault_limit = 16'h07FF;
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        chk("R7 full-scale mantissa", limit_q, 16'h0700);
        fault_limit = 16'hF807;
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        chk("R7 small mantissa", limit_q, 16'hF807);
    endtask

    task automatic t_collide();
        fault_limit = 16'h0008;
        step(1'b1, 16'h007F, 1'b1, 1'b0);
        chk("R8 restore wins", limit_q, 16'h0007);
        chk_flags("R8 write ignored", 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_accept();
        t_reject();
        t_override();
        t_restore();
        t_collide();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule